// File: doc/BRIEF.md
# Single-Channel Block Copier with Local Scratch Buffer

This block copies one contiguous block of bytes between host memory and a scratch buffer held inside the block. Software fills in four 64-bit parameter registers: source address, destination address, byte count and command. Setting the start bit of the command launches the copy. Software then polls the start bit, which stays at 1 while the copy is in flight, or waits for the completion pulse.

The scratch buffer appears at device addresses 0x40000 to 0x40FFF. One end of every copy is always this window; the other end is host memory. The direction bit picks which end is which. Host addresses leave the block through a 28-bit byte-wide master port, so any higher address bits are dropped.

The copy does not begin at once. It first waits a fixed number of clock cycles, set by a parameter. If the window-side range does not fit the buffer, the copy is refused at the end of that wait: a sticky error flag rises and no data moves. The host port follows valid/ready rules. The block raises `mem_req` and holds the address, direction and write data unchanged until `mem_ready` is seen high at a clock edge. Each such edge moves exactly one byte, and for reads `mem_rdata` is taken in that same cycle.

Top module: `lbuf_dma`

## Requirements
- R1: After reset, all four parameter registers read 0, `mem_req` is 0, `irq_done` is 0 and `xfer_err` is 0.
- R2: Writes are decoded at byte offsets 0x80 (source), 0x88 (destination), 0x90 (count) and 0x98 (command). A write with `reg_wr_wide`=1 stores all 64 bits. A write with `reg_wr_wide`=0 stores the low 32 bits and clears the upper 32. `reg_rd_data` shows the register selected by `reg_rd_ofs` in the same cycle.
- R3: A command write with bit 0 set is accepted, and the command then reads with bit 0 = 1. A command write with bit 0 clear leaves the command register unchanged.
- R4: While command bit 0 reads 1, writes to any of the four registers are ignored. This includes a write that falls in the same cycle as the final byte handshake.
- R5: `mem_req` stays low for START_DLY cycles after the clock edge that accepts the start. For a valid request, `mem_req` is high in the cycle that follows.
- R6: Command bit 1 = 0 copies from host to buffer: byte i is read from host address src+i and stored at buffer offset dst-0x40000+i. Bit 1 = 1 copies from buffer to host: buffer offset src-0x40000+i is written to host address dst+i with `mem_we`=1. Bytes go in ascending order.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values into the next cycle.
- R8: `mem_addr` carries the host-side address ANDed with 2^28-1.
- R9: Command bit 0 clears in the cycle after the last handshake. In that same cycle `irq_done` pulses high for exactly one cycle, if and only if command bit 2 was set.
- R10: The window-side range [a, a+count) must have a nonzero count, start at or above 0x40000 and end at or below 0x41000, with the sum taken without wrap. Otherwise, at the end of the start delay, `xfer_err` goes to 1, bit 0 clears, and no handshake or `irq_done` occurs. `xfer_err` stays at 1 until the next accepted start.
- R11: A valid copy performs exactly count handshakes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_ofs | input | 8 | Register write byte offset |
| reg_wr_wide | input | 1 | 1: 8-byte write, 0: 4-byte write |
| reg_wr_data | input | 64 | Register write data |
| reg_rd_ofs | input | 8 | Register read byte offset |
| reg_rd_data | output | 64 | Selected register value |
| mem_req | output | 1 | Host port request (valid) |
| mem_we | output | 1 | 1: write to host, 0: read from host |
| mem_addr | output | 28 | Masked host byte address |
| mem_wdata | output | 8 | Byte written to host |
| mem_rdata | input | 8 | Byte read from host, taken on handshake |
| mem_ready | input | 1 | Host port ready |
| irq_done | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | Sticky range error flag |

## Verification
Two events can land on the same clock edge: the final byte handshake, which clears the start bit, and a software write of a fresh start command. The bench provokes this by holding `mem_ready` low on a one-byte copy. It then raises `mem_ready` and the command write strobe together, so both meet at one edge. The outcome is judged in three ways. The command must read back as 0. No further request may appear across a full start delay. No completion pulse may occur, because the locked register file must have discarded the write.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  localparam int REG_W = 64;
  localparam logic [7:0] OFS_SRC = 8'h80;
  localparam logic [7:0] OFS_DST = 8'h88;
  localparam logic [7:0] OFS_CNT = 8'h90;
  localparam logic [7:0] OFS_CMD = 8'h98;
  localparam int CMD_GO  = 0;
  localparam int CMD_DIR = 1;
  localparam int CMD_IRQ = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_MOVE} seq_st_e;
endpackage

// File: rtl/lbd_regs.sv
module lbd_regs
  import lbd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_ofs,
  input  logic             wr_wide,
  input  logic [REG_W-1:0] wr_data,
  input  logic [7:0]       rd_ofs,
  output logic [REG_W-1:0] rd_data,
  input  logic             fin,
  output logic             go,
  output logic             run,
  output logic [REG_W-1:0] src,
  output logic [REG_W-1:0] dst,
  output logic [REG_W-1:0] cnt,
  output logic [REG_W-1:0] cmd
);
  logic [REG_W-1:0] wval;
  logic             wr_ok;

  assign wval  = wr_wide ? wr_data : {32'b0, wr_data[31:0]};
  assign wr_ok = wr_en && !cmd[CMD_GO];
  assign go    = wr_ok && (wr_ofs == OFS_CMD) && wval[CMD_GO];
  assign run   = cmd[CMD_GO];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0;
      dst <= '0;
      cnt <= '0;
      cmd <= '0;
    end else begin
      if (wr_ok) begin
        case (wr_ofs)
          OFS_SRC: src <= wval;
          OFS_DST: dst <= wval;
          OFS_CNT: cnt <= wval;
          OFS_CMD: if (wval[CMD_GO]) cmd <= wval;
          default: ;
        endcase
      end
      if (fin) cmd[CMD_GO] <= 1'b0;
    end
  end

  always_comb begin
    case (rd_ofs)
      OFS_SRC: rd_data = src;
      OFS_DST: rd_data = dst;
      OFS_CNT: rd_data = cnt;
      OFS_CMD: rd_data = cmd;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/lbd_lbuf.sv
module lbd_lbuf #(
  parameter int DEPTH = 4096,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/lbd_seq.sv
module lbd_seq
  import lbd_pkg::*;
#(
  parameter int          HOST_AW   = 28,
  parameter int          BUF_BYTES = 4096,
  parameter logic [63:0] BUF_BASE  = 64'h40000,
  parameter int          START_DLY = 64,
  localparam int BUF_AW = $clog2(BUF_BYTES),
  localparam int IDX_W  = BUF_AW + 1,
  localparam int DLY_W  = $clog2(START_DLY + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [REG_W-1:0]   src,
  input  logic [REG_W-1:0]   dst,
  input  logic [REG_W-1:0]   cnt,
  input  logic               dir,
  input  logic               irq_en,
  output logic               fin,
  output logic               irq_done,
  output logic               err,
  output logic               mem_req,
  output logic               mem_we,
  output logic [HOST_AW-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_ready,
  output logic               buf_we,
  output logic [BUF_AW-1:0]  buf_ofs,
  output logic [7:0]         buf_wdata,
  input  logic [7:0]         buf_rdata
);
  localparam logic [64:0] LIM = {1'b0, BUF_BASE} + 65'(BUF_BYTES);

  seq_st_e          st_q;
  logic [DLY_W-1:0] dly_q;
  logic [IDX_W-1:0] idx_q;
  logic [REG_W-1:0] win_base;
  logic [64:0]      win_end;
  logic             in_rng, dly_end, hs, last, done_ok;

  assign win_base = dir ? src : dst;
  assign win_end  = {1'b0, win_base} + {1'b0, cnt};
  assign in_rng   = (cnt != '0) && (win_base >= BUF_BASE) && (win_end <= LIM);
  assign dly_end  = (dly_q == DLY_W'(START_DLY - 1));

  assign mem_req   = (st_q == ST_MOVE);
  assign mem_we    = dir;
  assign mem_addr  = (dir ? dst[HOST_AW-1:0] : src[HOST_AW-1:0]) + HOST_AW'(idx_q);
  assign mem_wdata = buf_rdata;
  assign hs        = mem_req && mem_ready;
  assign last      = ((idx_q + IDX_W'(1)) == cnt[IDX_W-1:0]);

  assign buf_ofs   = win_base[BUF_AW-1:0] + idx_q[BUF_AW-1:0];
  assign buf_we    = hs && !dir;
  assign buf_wdata = mem_rdata;

  assign done_ok = hs && last;
  assign fin     = done_ok || ((st_q == ST_DELAY) && dly_end && !in_rng);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      dly_q    <= '0;
      idx_q    <= '0;
      irq_done <= 1'b0;
      err      <= 1'b0;
    end else begin
      irq_done <= done_ok && irq_en;
      case (st_q)
        ST_IDLE: if (go) begin
          st_q  <= ST_DELAY;
          dly_q <= '0;
          err   <= 1'b0;
        end
        ST_DELAY: begin
          if (dly_end) begin
            if (in_rng) begin
              st_q  <= ST_MOVE;
              idx_q <= '0;
            end else begin
              st_q <= ST_IDLE;
              err  <= 1'b1;
            end
          end else begin
            dly_q <= dly_q + 1'b1;
          end
        end
        ST_MOVE: if (hs) begin
          if (last) st_q <= ST_IDLE;
          else      idx_q <= idx_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbuf_dma.sv
module lbuf_dma
  import lbd_pkg::*;
#(
  parameter int          HOST_AW   = 28,
  parameter int          BUF_BYTES = 4096,
  parameter logic [63:0] BUF_BASE  = 64'h40000,
  parameter int          START_DLY = 64,
  localparam int BUF_AW = $clog2(BUF_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [7:0]         reg_wr_ofs,
  input  logic               reg_wr_wide,
  input  logic [63:0]        reg_wr_data,
  input  logic [7:0]         reg_rd_ofs,
  output logic [63:0]        reg_rd_data,
  output logic               mem_req,
  output logic               mem_we,
  output logic [HOST_AW-1:0] mem_addr,
  output logic [7:0]         mem_wdata,
  input  logic [7:0]         mem_rdata,
  input  logic               mem_ready,
  output logic               irq_done,
  output logic               xfer_err
);
  logic             go_w, fin_w, run_w;
  logic [REG_W-1:0] src_w, dst_w, cnt_w, cmd_w;
  logic             buf_we_w;
  logic [BUF_AW-1:0] buf_ofs_w;
  logic [7:0]       buf_wdata_w, buf_rdata_w;

  lbd_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (reg_wr_en),
    .wr_ofs  (reg_wr_ofs),
    .wr_wide (reg_wr_wide),
    .wr_data (reg_wr_data),
    .rd_ofs  (reg_rd_ofs),
    .rd_data (reg_rd_data),
    .fin     (fin_w),
    .go      (go_w),
    .run     (run_w),
    .src     (src_w),
    .dst     (dst_w),
    .cnt     (cnt_w),
    .cmd     (cmd_w)
  );

  lbd_seq #(
    .HOST_AW   (HOST_AW),
    .BUF_BYTES (BUF_BYTES),
    .BUF_BASE  (BUF_BASE),
    .START_DLY (START_DLY)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_w),
    .src       (src_w),
    .dst       (dst_w),
    .cnt       (cnt_w),
    .dir       (cmd_w[CMD_DIR]),
    .irq_en    (cmd_w[CMD_IRQ]),
    .fin       (fin_w),
    .irq_done  (irq_done),
    .err       (xfer_err),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ready (mem_ready),
    .buf_we    (buf_we_w),
    .buf_ofs   (buf_ofs_w),
    .buf_wdata (buf_wdata_w),
    .buf_rdata (buf_rdata_w)
  );

  lbd_lbuf #(.DEPTH(BUF_BYTES)) u_lbuf (
    .clk   (clk),
    .we    (buf_we_w),
    .waddr (buf_ofs_w),
    .wdata (buf_wdata_w),
    .raddr (buf_ofs_w),
    .rdata (buf_rdata_w)
  );
endmodule

// File: rtl/lbuf_dma_chk.sv
module lbuf_dma_chk #(
  parameter int HOST_AW = 28
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mem_req,
  input logic               mem_ready,
  input logic               mem_we,
  input logic [HOST_AW-1:0] mem_addr,
  input logic [7:0]         mem_wdata,
  input logic               irq_done,
  input logic               xfer_err,
  input logic               run,
  input logic [63:0]        src_r,
  input logic [63:0]        dst_r,
  input logic [63:0]        cnt_r
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R7
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !mem_req); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |=> !irq_done); // R9
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> !run && $past(run)); // R9
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_err) |-> !irq_done && !run); // R10
  AST_PARAM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(src_r) && $stable(dst_r) && $stable(cnt_r)); // R4
endmodule

bind lbuf_dma lbuf_dma_chk #(.HOST_AW(HOST_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .irq_done  (irq_done),
  .xfer_err  (xfer_err),
  .run       (run_w),
  .src_r     (src_w),
  .dst_r     (dst_w),
  .cnt_r     (cnt_w)
);

// File: tb/lbuf_dma_bench.sv
module lbuf_dma_bench;
  import lbd_pkg::*;
  localparam int          HOST_AW   = 28;
  localparam int          BUF_BYTES = 4096;
  localparam int          START_DLY = 64;
  localparam logic [63:0] WBASE     = 64'h40000;
  localparam logic [63:0] HMASK     = 64'h0FFF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic               reg_wr_en = 1'b0, reg_wr_wide = 1'b0;
  logic [7:0]         reg_wr_ofs = 8'h0, reg_rd_ofs = 8'h0;
  logic [63:0]        reg_wr_data = 64'h0, reg_rd_data;
  logic               mem_req, mem_we, mem_ready = 1'b0, irq_done, xfer_err;
  logic [HOST_AW-1:0] mem_addr;
  logic [7:0]         mem_wdata, mem_rdata;

  lbuf_dma u_lbuf_dma (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_ofs(reg_wr_ofs),
    .reg_wr_wide(reg_wr_wide), .reg_wr_data(reg_wr_data), .reg_rd_ofs(reg_rd_ofs),
    .reg_rd_data(reg_rd_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .irq_done(irq_done), .xfer_err(xfer_err)
  );

  int n_chk = 0, n_fail = 0, hs_cnt = 0, irq_cnt = 0, cyc = 0;
  logic rdy_force = 1'b0, rdy_val = 1'b0;

  typedef struct packed {
    logic               we;
    logic [HOST_AW-1:0] addr;
    logic [7:0]         data;
  } beat_t;
  beat_t expq[$];
  logic [7:0] bmodel [BUF_BYTES];

  function automatic logic [7:0] hpat(input logic [HOST_AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction
  assign mem_rdata = hpat(mem_addr);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ready pattern with back-pressure, or forced value
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    mem_ready = rdy_force ? rdy_val : ((cyc % 3) != 1);
  end

  // monitor / scoreboard
  initial begin : mon
    beat_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (irq_done) irq_cnt++;
        if (mem_req && mem_ready) begin
          hs_cnt++;
          if (expq.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R11: actual unexpected beat at %h expected none", mem_addr);
          end else begin
            e = expq.pop_front();
            check("R6 beat direction", 64'(mem_we), 64'(e.we));
            check("R8 R6 beat address", 64'(mem_addr), 64'(e.addr));
            if (e.we) check("R6 beat data", 64'(mem_wdata), 64'(e.data));
          end
        end
      end
    end
  end

  task automatic rwrite(input logic [7:0] ofs, input logic [63:0] d, input logic wide);
    @(posedge clk); #2;
    reg_wr_en = 1'b1; reg_wr_ofs = ofs; reg_wr_data = d; reg_wr_wide = wide;
    @(posedge clk); #2;
    reg_wr_en = 1'b0;
  endtask

  task automatic rread(input logic [7:0] ofs, output logic [63:0] d);
    reg_rd_ofs = ofs; #1; d = reg_rd_data;
  endtask

  task automatic wait_idle(input logic exp_irq);
    bit seen = 0;
    reg_rd_ofs = OFS_CMD;
    for (int k = 0; k < 20000 && !seen; k++) begin
      @(negedge clk);
      if (reg_rd_data[CMD_GO] == 1'b0) begin
        seen = 1;
        check("R9 irq_done with run clear", 64'(irq_done), 64'(exp_irq));
      end
    end
    check("R9 run bit clears", 64'(seen), 64'd1);
  endtask

  task automatic run_xfer(input logic [63:0] src, input logic [63:0] dst, input int cnt,
                          input logic [63:0] cmd, input logic ok, input logic poke);
    int hs0, irq0;
    logic early;
    logic [63:0] v;
    rwrite(OFS_SRC, src, 1'b1);
    rwrite(OFS_DST, dst, 1'b1);
    rwrite(OFS_CNT, 64'(cnt), 1'b1);
    if (ok) begin
      for (int i = 0; i < cnt; i++) begin
        if (!cmd[CMD_DIR]) begin
          expq.push_back('{we: 1'b0, addr: HOST_AW'((src + 64'(i)) & HMASK), data: 8'h00});
          bmodel[32'(dst - WBASE) + i] = hpat(HOST_AW'((src + 64'(i)) & HMASK));
        end else begin
          expq.push_back('{we: 1'b1, addr: HOST_AW'((dst + 64'(i)) & HMASK),
                           data: bmodel[32'(src - WBASE) + i]});
        end
      end
    end
    hs0 = hs_cnt; irq0 = irq_cnt;
    rwrite(OFS_CMD, cmd, 1'b0);
    early = 1'b0;
    for (int n = 1; n <= START_DLY; n++) begin
      @(negedge clk);
      if (mem_req) early = 1'b1;
    end
    check("R5 no request during start delay", 64'(early), 64'd0);
    @(negedge clk);
    check("R5 R10 request right after delay", 64'(mem_req), 64'(ok));
    if (poke) begin
      rread(OFS_CMD, v);
      check("R3 run reads 1 while active", 64'(v[CMD_GO]), 64'd1);
      rwrite(OFS_SRC, 64'hDEAD_BEEF, 1'b1);
      rwrite(OFS_CMD, 64'h7, 1'b0);
      rread(OFS_SRC, v);
      check("R4 source locked while active", v, src);
      rread(OFS_CMD, v);
      check("R4 command locked while active", v, cmd);
    end
    wait_idle(ok && cmd[CMD_IRQ]);
    check("R11 all expected beats seen", 64'(expq.size()), 64'd0);
    check("R11 beat count", 64'(hs_cnt - hs0), ok ? 64'(cnt) : 64'd0);
    check("R9 irq pulse count", 64'(irq_cnt - irq0), (ok && cmd[CMD_IRQ]) ? 64'd1 : 64'd0);
    check("R10 error flag", 64'(xfer_err), 64'(!ok));
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [63:0] v;
    bit bad;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rread(OFS_SRC, v); check("R1 source reset", v, 64'h0);
    rread(OFS_DST, v); check("R1 destination reset", v, 64'h0);
    rread(OFS_CNT, v); check("R1 count reset", v, 64'h0);
    rread(OFS_CMD, v); check("R1 command reset", v, 64'h0);
    check("R1 no request", 64'(mem_req), 64'd0);
    check("R1 no irq", 64'(irq_done), 64'd0);
    check("R1 no error", 64'(xfer_err), 64'd0);

    // R2 write widths
    rwrite(OFS_SRC, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    rread(OFS_SRC, v); check("R2 wide write", v, 64'hFFFF_FFFF_FFFF_FFFF);
    rwrite(OFS_SRC, 64'h1234_5678_9ABC_DEF0, 1'b0);
    rread(OFS_SRC, v); check("R2 narrow write clears upper", v, 64'h0000_0000_9ABC_DEF0);
    rwrite(OFS_CNT, 64'hAAAA_0000_0000_0033, 1'b1);
    rread(OFS_CNT, v); check("R2 count register", v, 64'hAAAA_0000_0000_0033);

    // R3 command without start bit ignored
    rwrite(OFS_CMD, 64'h6, 1'b0);
    rread(OFS_CMD, v); check("R3 start-clear command ignored", v, 64'h0);

    // host to buffer, high address bits dropped, irq, locking pokes
    run_xfer(64'h0000_00F0_1234_5600, 64'h40010, 20, 64'h5, 1'b1, 1'b1);
    // buffer to host, no irq
    run_xfer(64'h40010, 64'h0000_0000_0000_2000, 20, 64'h3, 1'b1, 1'b0);
    // out of range: runs past window end
    run_xfer(64'h0, 64'h40FF8, 16, 64'h5, 1'b0, 1'b0);
    // exact fit at window top clears sticky error
    run_xfer(64'h0000_0000_0300_0100, 64'h40FF0, 16, 64'h1, 1'b1, 1'b0);
    // read back with masked destination
    run_xfer(64'h40FF0, 64'h0000_0001_2345_0000, 16, 64'h7, 1'b1, 1'b0);
    // wrap-around range
    run_xfer(64'h0, 64'hFFFF_FFFF_FFFF_FFF8, 16, 64'h1, 1'b0, 1'b0);
    // zero count
    run_xfer(64'h0, 64'h40000, 0, 64'h5, 1'b0, 1'b0);
    // below window, buffer-to-host direction
    run_xfer(64'h3FFF0, 64'h100, 32, 64'h7, 1'b0, 1'b0);

    // R4: command write in the same cycle as the final handshake
    rdy_force = 1'b1; rdy_val = 1'b0;
    rwrite(OFS_SRC, 64'h0000_0000_0000_0777, 1'b1);
    rwrite(OFS_DST, 64'h40200, 1'b1);
    rwrite(OFS_CNT, 64'd1, 1'b1);
    expq.push_back('{we: 1'b0, addr: HOST_AW'(64'h777), data: 8'h00});
    rwrite(OFS_CMD, 64'h1, 1'b0);
    repeat (START_DLY + 3) @(negedge clk);
    check("R7 request held under back-pressure", 64'(mem_req), 64'd1);
    @(posedge clk); #2;
    rdy_val = 1'b1; mem_ready = 1'b1;
    reg_wr_en = 1'b1; reg_wr_ofs = OFS_CMD; reg_wr_data = 64'h5; reg_wr_wide = 1'b0;
    @(posedge clk); #2;
    reg_wr_en = 1'b0; rdy_val = 1'b0; mem_ready = 1'b0;
    @(negedge clk);
    rread(OFS_CMD, v); check("R4 same-cycle command write dropped", v, 64'h0);
    rdy_force = 1'b0;
    bad = 0;
    for (int n = 0; n < START_DLY + 6; n++) begin
      @(negedge clk);
      if (mem_req || irq_done) bad = 1;
    end
    check("R4 no second transfer launched", 64'(bad), 64'd0);
    check("R11 single beat consumed", 64'(expq.size()), 64'd0);

    finish_up();
  end
endmodule